// File: doc/BRIEF.md
# Boundary-Scan Test Port Controller

This block is the sequencing core of a boundary-scan test port. A sixteen-state machine advances on each rising edge of the test clock `tck`, steered by the mode-select input `tms`. It owns the instruction path: a serial shift stage between `tdi` and `tdo`, and a separate parallel instruction latch that holds the active instruction. The present state is exposed as a fixed 4-bit code, so a debugger or a neighbouring block can decode it directly.

Data registers live outside the block. The controller drives capture, shift and update enables for both the instruction and data paths. It takes the serial output of the selected external data register on `dr_so`. It also flags whether the active instruction is the bypass opcode or the identification opcode.

Instruction transfer happens on the falling edge of `tck` while the state is Update-IR. Serial output is likewise registered on the falling edge. It is driven only while shifting and is released to high impedance otherwise.

The states are Test-Logic-Reset (0xF), Run-Test/Idle (0xC), Select-DR (0x7), Capture-DR (0x6), Shift-DR (0x2), Exit1-DR (0x1), Pause-DR (0x3), Exit2-DR (0x0), Update-DR (0x5), Select-IR (0x4), Capture-IR (0xE), Shift-IR (0xA), Exit1-IR (0x9), Pause-IR (0xB), Exit2-IR (0x8) and Update-IR (0xD).

The transitions, written as tms=1 / tms=0, are:
- Test-Logic-Reset: itself / Run-Test/Idle
- Run-Test/Idle: Select-DR / itself
- Select-DR: Select-IR / Capture-DR
- Select-IR: Test-Logic-Reset / Capture-IR
- Capture: Exit1 / Shift
- Shift: Exit1 / itself
- Exit1: Update / Pause
- Pause: Exit2 / itself
- Exit2: Update / Shift
- Update: Select-DR / Run-Test/Idle

The Capture, Shift, Exit1, Pause, Exit2 and Update rows hold for both the DR and the IR branch.

Top module: `tap_ctrl`

## Requirements
- R1: Driving `trst_n` low forces the state to 0xF at once, without waiting for a clock. It loads the identification opcode (4'b0010 by default, or all ones when identification is disabled) into the instruction latch and deasserts `tdo_oe`.
- R2: `state_code` carries the 4-bit codes listed above for every state.
- R3: The IR branch follows the transition list: Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR, including the path from Exit2-IR back to Shift-IR.
- R4: From Update-IR, tms=0 leads to Run-Test/Idle and tms=1 leads to Select-DR.
- R5: Test-Logic-Reset, Run-Test/Idle, both Select states and the whole DR branch follow the transition list.
- R6: Five consecutive rising edges with tms=1 reach state 0xF from any state.
- R7: A rising edge in Capture-IR loads the shift stage with a pattern whose bit 0 is 1 and whose other bits are 0.
- R8: Each rising edge in Shift-IR moves the shift stage one bit toward bit 0. `tdi` enters at the most significant bit, and bit 0 is the next value presented on `tdo`.
- R9: While in Pause-IR, the shift stage keeps its content.
- R10: The instruction latch takes the shift-stage value at the falling edge of `tck` in Update-IR, and at no other time outside reset. At the rising edge that enters Update-IR, it still holds the old instruction.
- R11: At each falling edge in Test-Logic-Reset, the latch reloads the identification opcode.
- R12: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is 1 exactly when the state is Shift-IR or Shift-DR. In Shift-IR `tdo` carries shift-stage bit 0, and in Shift-DR it carries `dr_so`.
- R13: Each of the six enables is high only in its own state (capture/shift/update for IR and DR), so at most one is high. `sel_bypass` is high when the instruction is all ones, and `sel_idcode` is high when it equals the identification opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| dr_so | input | 1 | Serial output of the selected external data register |
| tdo | output | 1 | Serial data out, high impedance when not shifting |
| tdo_oe | output | 1 | Output enable for `tdo` |
| state_code | output | 4 | Present state code |
| instr | output | IR_W | Active instruction |
| capture_ir | output | 1 | High in Capture-IR |
| shift_ir | output | 1 | High in Shift-IR |
| update_ir | output | 1 | High in Update-IR |
| capture_dr | output | 1 | High in Capture-DR |
| shift_dr | output | 1 | High in Shift-DR |
| update_dr | output | 1 | High in Update-DR |
| sel_bypass | output | 1 | Active instruction is the bypass opcode |
| sel_idcode | output | 1 | Active instruction is the identification opcode |

## Verification
A wrong next-state decision shows on `state_code` half a clock after the offending rising edge, and the enables move with it. The bench compares the code after every step against an independent transition model. A corrupted shift stage is invisible until it is either shifted out, which shows on `tdo` at the following falling edge, or transferred in Update-IR, which shows on `instr` and the select strobes. The bench therefore shifts known patterns through pauses and exits and checks the bits that reach `tdo` and the latch. A latch that loads on the wrong edge is caught by sampling `instr` just after the rising edge into Update-IR, when it must still hold the old value.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET   = 4'hF,
        ST_IDLE    = 4'hC,
        ST_SEL_DR  = 4'h7,
        ST_CAP_DR  = 4'h6,
        ST_SH_DR   = 4'h2,
        ST_EX1_DR  = 4'h1,
        ST_PAU_DR  = 4'h3,
        ST_EX2_DR  = 4'h0,
        ST_UPD_DR  = 4'h5,
        ST_SEL_IR  = 4'h4,
        ST_CAP_IR  = 4'hE,
        ST_SH_IR   = 4'hA,
        ST_EX1_IR  = 4'h9,
        ST_PAU_IR  = 4'hB,
        ST_EX2_IR  = 4'h8,
        ST_UPD_IR  = 4'hD
    } tap_state_e;

    typedef struct packed {
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
        logic cap_dr;
        logic sh_dr;
        logic upd_dr;
        logic in_reset;
    } tap_en_t;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import tap_pkg::*;
#(
    parameter int RESET_RUN = 5
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output tap_en_t    en
);
    localparam int CW = $clog2(RESET_RUN + 1);

    tap_state_e nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    always_comb begin
        en          = '0;
        en.cap_ir   = (state == ST_CAP_IR);
        en.sh_ir    = (state == ST_SH_IR);
        en.upd_ir   = (state == ST_UPD_IR);
        en.cap_dr   = (state == ST_CAP_DR);
        en.sh_dr    = (state == ST_SH_DR);
        en.upd_dr   = (state == ST_UPD_DR);
        en.in_reset = (state == ST_RESET);
    end

    // Run length of tms=1 edges, used only by the reset-path check.
    logic [CW-1:0] ones_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                                ones_q <= '0;
        else if (!tms)                              ones_q <= '0;
        else if (ones_q != CW'(RESET_RUN))          ones_q <= ones_q + 1'b1;
    end

    assert_tms_run_reset_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && ones_q >= CW'(RESET_RUN - 1)) |=> (state == ST_RESET));

    assert_capir_exit_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR && tms) |=> (state == ST_EX1_IR));

    assert_exit2_reshift_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_EX2_IR && !tms) |=> (state == ST_SH_IR));

    assert_update_to_idle_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_IR && !tms) |=> (state == ST_IDLE));

    assert_update_to_seldr_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_IR && tms) |=> (state == ST_SEL_DR));

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir #(
    parameter int          IR_W     = 4,
    parameter logic [IR_W-1:0] RESET_OP = '1
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            capture,
    input  logic            shift,
    input  logic            update,
    input  logic            in_reset,
    output logic            so,
    output logic [IR_W-1:0] instr
);
    localparam logic [IR_W-1:0] CAPT_PAT = IR_W'(1);

    logic [IR_W-1:0] sr_q;

    // Shift stage: rising-edge domain.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)      sr_q <= CAPT_PAT;
        else if (capture) sr_q <= CAPT_PAT;
        else if (shift)   sr_q <= {tdi, sr_q[IR_W-1:1]};
    end

    assign so = sr_q[0];

    // Instruction latch: falling-edge domain.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)       instr <= RESET_OP;
        else if (in_reset) instr <= RESET_OP;
        else if (update)   instr <= sr_q;
    end

    assert_capture_pattern_R7: assert property (@(posedge tck) disable iff (!trst_n)
        capture |=> (sr_q[1:0] == 2'b01));

    assert_shift_hold_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (!capture && !shift) |=> $stable(sr_q));

    assert_latch_quiet_R10: assert property (@(negedge tck) disable iff (!trst_n)
        (!update && !in_reset) |=> $stable(instr));

endmodule

// File: rtl/tap_tdo.sv
`timescale 1ns/1ps
module tap_tdo (
    input  logic tck,
    input  logic trst_n,
    input  logic sh_ir,
    input  logic sh_dr,
    input  logic ir_so,
    input  logic dr_so,
    output logic tdo_q,
    output logic tdo_oe
);
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q  <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= sh_ir | sh_dr;
            if (sh_ir)      tdo_q <= ir_so;
            else if (sh_dr) tdo_q <= dr_so;
        end
    end

    assert_oe_idle_R12: assert property (@(negedge tck) disable iff (!trst_n)
        (!sh_ir && !sh_dr) |=> !tdo_oe);

    assert_oe_shift_R12: assert property (@(negedge tck) disable iff (!trst_n)
        (sh_ir || sh_dr) |=> tdo_oe);

endmodule

// File: rtl/tap_ctrl.sv
`timescale 1ns/1ps
module tap_ctrl
    import tap_pkg::*;
#(
    parameter int              IR_W       = 4,
    parameter bit              HAS_IDCODE = 1'b1,
    parameter logic [IR_W-1:0] IDCODE_OP  = IR_W'(2)
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    input  logic            dr_so,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [3:0]      state_code,
    output logic [IR_W-1:0] instr,
    output logic            capture_ir,
    output logic            shift_ir,
    output logic            update_ir,
    output logic            capture_dr,
    output logic            shift_dr,
    output logic            update_dr,
    output logic            sel_bypass,
    output logic            sel_idcode
);
    localparam logic [IR_W-1:0] BYPASS_OP = '1;
    localparam logic [IR_W-1:0] RESET_OP  = HAS_IDCODE ? IDCODE_OP : BYPASS_OP;

    tap_state_e state;
    tap_en_t    en;
    logic       ir_so;
    logic       tdo_q;

    tap_fsm #(.RESET_RUN(5)) fsm_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .en(en)
    );

    tap_ir #(.IR_W(IR_W), .RESET_OP(RESET_OP)) ir_i (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture(en.cap_ir), .shift(en.sh_ir), .update(en.upd_ir),
        .in_reset(en.in_reset), .so(ir_so), .instr(instr)
    );

    tap_tdo tdo_i (
        .tck(tck), .trst_n(trst_n), .sh_ir(en.sh_ir), .sh_dr(en.sh_dr),
        .ir_so(ir_so), .dr_so(dr_so), .tdo_q(tdo_q), .tdo_oe(tdo_oe)
    );

    assign tdo        = tdo_oe ? tdo_q : 1'bz;
    assign state_code = state;
    assign capture_ir = en.cap_ir;
    assign shift_ir   = en.sh_ir;
    assign update_ir  = en.upd_ir;
    assign capture_dr = en.cap_dr;
    assign shift_dr   = en.sh_dr;
    assign update_dr  = en.upd_dr;
    assign sel_bypass = (instr == BYPASS_OP);
    assign sel_idcode = HAS_IDCODE && (instr == IDCODE_OP);

    assert_enables_onehot_R13: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({capture_ir, shift_ir, update_ir, capture_dr, shift_dr, update_dr}));

endmodule

// File: tb/tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module tap_ctrl_tb_top;
    localparam int         IR_W = 4;
    localparam logic [3:0] IDC  = 4'b0010;
    localparam logic [3:0] CAPT = 4'b0001;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b0, tdi = 1'b0, dr_so = 1'b0;
    wire  tdo;
    logic tdo_oe, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr, sel_byp, sel_id;
    logic [3:0]      state_code;
    logic [IR_W-1:0] instr;

    tap_ctrl dut_i (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .dr_so(dr_so),
        .tdo(tdo), .tdo_oe(tdo_oe), .state_code(state_code), .instr(instr),
        .capture_ir(cap_ir), .shift_ir(sh_ir), .update_ir(upd_ir),
        .capture_dr(cap_dr), .shift_dr(sh_dr), .update_dr(upd_dr),
        .sel_bypass(sel_byp), .sel_idcode(sel_id)
    );

    always #2.5 tck = ~tck;

    int  n_chk = 0, n_bad = 0;
    bit  summary_done = 0;

    typedef struct {
        logic [3:0] st;
        logic [3:0] ins;
        logic       oe;
        logic       dout;
        string      req;
    } item_t;
    item_t q[$];
    event  sample_ev;

    logic [3:0] rs, rsr, rinstr;
    logic       roe, rtdo;

    function automatic logic [3:0] nxt(input logic [3:0] s, input logic m);
        case (s)
            4'hF: nxt = m ? 4'hF : 4'hC;
            4'hC: nxt = m ? 4'h7 : 4'hC;
            4'h7: nxt = m ? 4'h4 : 4'h6;
            4'h6: nxt = m ? 4'h1 : 4'h2;
            4'h2: nxt = m ? 4'h1 : 4'h2;
            4'h1: nxt = m ? 4'h5 : 4'h3;
            4'h3: nxt = m ? 4'h0 : 4'h3;
            4'h0: nxt = m ? 4'h5 : 4'h2;
            4'h5: nxt = m ? 4'h7 : 4'hC;
            4'h4: nxt = m ? 4'hF : 4'hE;
            4'hE: nxt = m ? 4'h9 : 4'hA;
            4'hA: nxt = m ? 4'h9 : 4'hA;
            4'h9: nxt = m ? 4'hD : 4'hB;
            4'hB: nxt = m ? 4'h8 : 4'hB;
            4'h8: nxt = m ? 4'hD : 4'hA;
            default: nxt = m ? 4'h7 : 4'hC;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic ref_reset();
        rs = 4'hF; rsr = CAPT; rinstr = IDC; roe = 1'b0; rtdo = 1'b0;
    endtask

    // Driver: one TCK cycle, pushes the expected outcome for the monitor.
    task automatic step(input logic m, input logic d, input logic dso, input string req);
        logic [3:0] old;
        tms = m; tdi = d; dr_so = dso;
        @(posedge tck);
        old = rs;
        if (old == 4'hE)      rsr = CAPT;
        else if (old == 4'hA) rsr = {d, rsr[3:1]};
        rs = nxt(old, m);
        #1;
        chk(instr == rinstr, "R10", "instr before falling edge", instr, rinstr);
        chk(tdo_oe == roe, "R12", "tdo_oe before falling edge", tdo_oe, roe);
        @(negedge tck);
        if (rs == 4'hD)      rinstr = rsr;
        else if (rs == 4'hF) rinstr = IDC;
        roe = (rs == 4'hA) || (rs == 4'h2);
        if (rs == 4'hA)      rtdo = rsr[0];
        else if (rs == 4'h2) rtdo = dso;
        #1;
        q.push_back('{rs, rinstr, roe, rtdo, req});
        -> sample_ev;
    endtask

    // Monitor: pops expected items and compares them with the ports.
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(state_code == it.st, it.req, "state", state_code, it.st);
                chk(instr == it.ins, (it.st == 4'hF) ? "R11" : "R10", "instr", instr, it.ins);
                chk(tdo_oe == it.oe, "R12", "tdo_oe", tdo_oe, it.oe);
                if (it.oe) chk(tdo === it.dout, (it.st == 4'hA) ? "R8" : "R12", "tdo", tdo, it.dout);
                chk({cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr} ==
                    {it.st == 4'hE, it.st == 4'hA, it.st == 4'hD,
                     it.st == 4'h6, it.st == 4'h2, it.st == 4'h5},
                    "R13", "enables",
                    {cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr}, 0);
                chk(sel_byp == (it.ins == 4'hF), "R13", "sel_bypass", sel_byp, it.ins == 4'hF);
                chk(sel_id == (it.ins == IDC), "R13", "sel_idcode", sel_id, it.ins == IDC);
            end
        end
    end

    task automatic to_shift_ir();
        step(1, 0, 0, "R5"); step(1, 0, 0, "R5");
        step(0, 0, 0, "R5"); step(0, 0, 0, "R7");
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        ref_reset();
        #12;
        chk(state_code == 4'hF, "R1", "reset state", state_code, 4'hF);
        chk(state_code == 4'hF, "R2", "reset code", state_code, 4'hF);
        chk(instr == IDC, "R1", "reset instr", instr, IDC);
        chk(tdo_oe == 1'b0, "R1", "reset tdo_oe", tdo_oe, 0);
        chk(sel_id == 1'b1, "R13", "reset sel_idcode", sel_id, 1);
        @(negedge tck); #1; trst_n = 1'b1;

        step(1, 0, 0, "R5"); step(0, 0, 0, "R5"); step(0, 0, 0, "R5");
        to_shift_ir();
        // load all ones (bypass) with a pause
        step(0, 1, 0, "R8"); step(0, 1, 0, "R8"); step(0, 1, 0, "R8");
        step(1, 1, 0, "R3"); step(0, 0, 0, "R3"); step(0, 0, 0, "R9");
        step(0, 1, 0, "R9"); step(1, 0, 0, "R3"); step(1, 0, 0, "R3");
        step(1, 0, 0, "R4");
        // DR branch
        step(0, 0, 0, "R5"); step(0, 0, 1, "R5"); step(0, 0, 1, "R12");
        step(0, 0, 0, "R12"); step(1, 0, 1, "R5"); step(0, 0, 0, "R5");
        step(0, 0, 0, "R5"); step(1, 0, 0, "R5"); step(0, 0, 1, "R5");
        step(1, 0, 0, "R5"); step(1, 0, 0, "R5"); step(0, 0, 0, "R5");
        // load 0110 through Exit2 -> Shift
        to_shift_ir();
        step(0, 0, 0, "R8"); step(1, 1, 0, "R3"); step(0, 0, 0, "R3");
        step(1, 0, 0, "R3"); step(0, 0, 0, "R3"); step(0, 1, 0, "R8");
        step(1, 0, 0, "R3"); step(1, 0, 0, "R3"); step(0, 0, 0, "R4");
        // five ones from Shift-IR and from Pause-DR
        to_shift_ir();
        for (int i = 0; i < 5; i++) step(1, 0, 0, "R6");
        step(0, 0, 0, "R5"); step(1, 0, 0, "R5"); step(0, 0, 0, "R5");
        step(0, 0, 0, "R5"); step(1, 0, 0, "R5"); step(0, 0, 0, "R5");
        for (int i = 0; i < 5; i++) step(1, 0, 0, "R6");
        // asynchronous reset in the middle of Shift-IR
        step(0, 0, 0, "R5");
        to_shift_ir();
        step(0, 1, 0, "R8");
        @(posedge tck); #2; trst_n = 1'b0; #1;
        chk(state_code == 4'hF, "R1", "async reset state", state_code, 4'hF);
        chk(instr == IDC, "R1", "async reset instr", instr, IDC);
        chk(tdo_oe == 1'b0, "R1", "async reset tdo_oe", tdo_oe, 0);
        @(negedge tck); #1; trst_n = 1'b1; ref_reset();
        step(0, 0, 0, "R5"); step(1, 0, 0, "R5");
        #20;
        finish_run();
    end
endmodule